// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory built so that reads and writes can follow each other on every enabled clock with no idle cycles. Each operation is issued as an address and control word on one clock edge. Its data occupies the shared data slot two enabled cycles later. For a read, the output register presents the word in that slot. For a write, the caller drives the word in that slot and it is sampled at the end of the slot. Writes whose data has been sampled, but not yet placed in the array, sit in a pending register. Reads that hit such a write, or the write whose data is on the bus in the same edge, get the newer bytes forwarded. The bus therefore never needs a dead turnaround cycle.

A clock enable freezes the entire pipeline. Three chip enables qualify each new operation. Per-byte write selects mask the lanes that are written. A four-beat burst sequencer advances the two low address bits in linear or interleaved order. The order is picked by a static mode input.

Top module: `lw_sram`

## Requirements
- R1: A read issued at enabled edge k shows its word on `rdata` with `rd_oe` high after enabled edge k+2. Both are held until the next enabled edge.
- R2: For a write issued at enabled edge k, `wdata` is sampled at enabled edge k+3. This is the end of the same slot a read issued at k would use.
- R3: Operations may follow in any order on consecutive enabled edges. A read always returns the array contents with every earlier-issued write applied, including writes whose data is still pending or is being sampled at the read's output edge.
- R4: A write changes byte lane i (bits 8i+7 down to 8i) only when `be[i]` was 1 when the operation was loaded. Other lanes keep their value.
- R5: A load cycle (`ld`=1) issues an operation only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: it accesses nothing, leaves `rd_oe` low in its slot, and ends any burst.
- R6: `rd_oe` is low in the slot of a write, a deselect, or an idle cycle.
- R7: With `cke` low, the clock edge has no effect. All inputs are ignored, and `rdata`, `rd_oe` and all pending state hold.
- R8: With `ld`=0 during an active burst, the next beat keeps the upper address bits, read/write type and byte selects of the loading cycle. For beat n, the low two bits are (start+n) mod 4 when `ilv`=0 and start XOR n when `ilv`=1. Beat n is counted modulo 4 from 0 at the load, so the fifth beat wraps to the start.
- R9: With `ld`=0 and no burst active (after reset or after a deselect), the cycle is idle and nothing is written.
- R10: Reset (`rst_n` low, synchronous) clears `rd_oe`, the burst state and all in-flight operations. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low stalls every stage |
| ld | input | 1 | 1 loads a new address, 0 continues the burst |
| we | input | 1 | 1 write, 0 read (load cycles) |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| be | input | NB | Byte write selects, one per lane |
| addr | input | AW | Word address |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | 8*NB | Write data for the current slot |
| rdata | output | 8*NB | Registered read data |
| rd_oe | output | 1 | High when the current slot carries read data |

## Verification
The bench builds the block with AW=4 and NB=2, so there are 16 words of two lanes each. With this size it can fill and read back every address. It sweeps all four byte-select patterns on every address, every start offset in both burst orders for reads and writes, and all eight chip-enable combinations. A long pseudo-random mix of loads, continuations, deselects and stalls over the small array then makes same-address write-to-read hits at every forwarding distance frequent. Every read is compared against a program-order model.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 8,
  parameter int NB = 4,
  localparam int DW = 8 * NB,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          ld,
  input  logic          we,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic [NB-1:0] be,
  input  logic [AW-1:0] addr,
  input  logic          ilv,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic          b_act, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  logic [NB-1:0] b_be;

  logic          s0_v, s0_we, s1_v, s1_we, s2_w, p_v;
  logic [AW-1:0] s0_a, s1_a, s2_a, p_a;
  logic [NB-1:0] s0_be, s1_be, s2_be, p_be;
  logic [DW-1:0] p_d, fwd;

  wire       sel     = !sel_a_n && sel_b && !sel_c_n;
  wire [1:0] nxt_cnt = b_cnt + 2'd1;
  wire [1:0] nxt_off = ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);

  wire          i_v  = ld ? sel : b_act;
  wire          i_we = ld ? we  : b_we;
  wire [NB-1:0] i_be = ld ? be  : b_be;
  wire [AW-1:0] i_a  = ld ? addr : {b_base[AW-1:2], nxt_off};

  always_comb begin
    fwd = mem[s1_a];
    for (int i = 0; i < NB; i++) begin
      if (p_v && p_a == s1_a && p_be[i]) fwd[8*i +: 8] = p_d[8*i +: 8];
      if (s2_w && s2_a == s1_a && s2_be[i]) fwd[8*i +: 8] = wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act <= 1'b0;
      s0_v  <= 1'b0;
      s1_v  <= 1'b0;
      s2_w  <= 1'b0;
      p_v   <= 1'b0;
      rd_oe <= 1'b0;
      rdata <= '0;
    end else if (cke) begin
      if (ld) begin
        b_act <= sel;
        if (sel) begin
          b_base <= addr;
          b_cnt  <= 2'd0;
          b_we   <= we;
          b_be   <= be;
        end
      end else if (b_act) begin
        b_cnt <= nxt_cnt;
      end
      s0_v  <= i_v;
      s0_we <= i_we;
      s0_be <= i_be;
      s0_a  <= i_a;
      s1_v  <= s0_v;
      s1_we <= s0_we;
      s1_be <= s0_be;
      s1_a  <= s0_a;
      s2_w  <= s1_v && s1_we;
      s2_be <= s1_be;
      s2_a  <= s1_a;
      p_v   <= s2_w;
      p_be  <= s2_be;
      p_a   <= s2_a;
      p_d   <= wdata;
      rd_oe <= s1_v && !s1_we;
      if (s1_v && !s1_we) rdata <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cke && p_v)
      for (int i = 0; i < NB; i++)
        if (p_be[i]) mem[p_a][8*i +: 8] <= p_d[8*i +: 8];
  end

endmodule

module lw_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          ld,
  input logic          sel,
  input logic          b_act,
  input logic          b_we,
  input logic          s0_v,
  input logic          s0_we,
  input logic          s2_w,
  input logic          p_v,
  input logic          rd_oe,
  input logic [DW-1:0] rdata
);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(rd_oe) && $stable(rdata) && $stable(p_v));

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    s2_w |-> !rd_oe);

  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cke && ld && !sel |=> !s0_v && !b_act);

  a_r9_no_burst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cke && !ld && !b_act |=> !s0_v);

  a_r8_burst_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
    cke && !ld && b_act |=> s0_v && s0_we == $past(b_we));

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !rd_oe && !p_v && !b_act);

endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .ld(ld), .sel(sel), .b_act(b_act),
  .b_we(b_we), .s0_v(s0_v), .s0_we(s0_we), .s2_w(s2_w), .p_v(p_v),
  .rd_oe(rd_oe), .rdata(rdata)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, ld = 1'b1, we = 1'b0, ilv = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [NB-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_oe;

  always #4 clk = ~clk;

  lw_sram #(.AW(AW), .NB(NB)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .cke(cke), .ld(ld), .we(we),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .be(be),
    .addr(addr), .ilv(ilv), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mdl [16];
  int hk [3];
  logic [DW-1:0] hd [3];
  string ht [3];
  logic prev_stall = 1'b0;
  logic bact = 1'b0, bwe = 1'b0;
  logic [1:0] bbe = '0, bcnt = '0;
  logic [3:0] bbase = '0;
  logic [31:0] lf = 32'h1234_5679;

  task automatic rnd();
    lf ^= lf << 13;
    lf ^= lf >> 17;
    lf ^= lf << 5;
  endtask

  task automatic check(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_slot();
    string t;
    t = prev_stall ? "R7" : ht[2];
    if (hk[2] == 1)
      check(rd_oe === 1'b1 && rdata === hd[2], {t, "/R1/R3 read"}, {rd_oe, rdata}, {1'b1, hd[2]});
    else
      check(rd_oe === 1'b0, {t, "/R6 no drive"}, {16'h0, rd_oe}, '0);
  endtask

  task automatic clr_hist();
    for (int i = 0; i < 3; i++) begin
      hk[i] = 0; hd[i] = '0; ht[i] = "R10";
    end
    bact = 1'b0;
  endtask

  // en = {sel_a_n, sel_b, sel_c_n}; 3'b010 selects
  task automatic step(input logic c, input logic l, input logic w, input logic [2:0] en,
                      input logic [1:0] b, input logic [3:0] a, input logic il, input string t);
    int k;
    logic [3:0] ia;
    logic [1:0] ibe;
    logic [DW-1:0] d;
    chk_slot();
    rnd();
    cke = c; ld = l; we = w; {sel_a_n, sel_b, sel_c_n} = en; be = b; addr = a; ilv = il;
    wdata = (c && hk[2] == 2) ? hd[2] : lf[31:16];
    k = 0; ia = '0; ibe = '0; d = '0;
    if (c) begin
      if (l) begin
        if (en == 3'b010) begin
          bact = 1'b1; bwe = w; bbe = b; bbase = a; bcnt = 2'd0;
          k = w ? 2 : 1; ia = a; ibe = b;
        end else bact = 1'b0;
      end else if (bact) begin
        bcnt = bcnt + 2'd1;
        ia = {bbase[3:2], il ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt)};
        k = bwe ? 2 : 1; ibe = bbe;
      end
      if (k == 2) begin
        rnd();
        d = lf[15:0];
        for (int i = 0; i < NB; i++) if (ibe[i]) mdl[ia][8*i +: 8] = d[8*i +: 8];
      end else if (k == 1) d = mdl[ia];
    end
    @(posedge clk);
    if (c) begin
      hk[2] = hk[1]; hd[2] = hd[1]; ht[2] = ht[1];
      hk[1] = hk[0]; hd[1] = hd[0]; ht[1] = ht[0];
      hk[0] = k; hd[0] = d; ht[0] = t;
    end
    prev_stall = !c;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 3'b100, 2'b00, 4'h0, 0, "R5");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cke = 1'b1;
    clr_hist();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(rd_oe === 1'b0, "R10 reset rd_oe", {16'h0, rd_oe}, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int a = 0; a < 16; a++) step(1, 1, 1, 3'b010, 2'b11, a[3:0], 0, "R2");
    for (int a = 0; a < 16; a++) step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R1");

    for (int a = 0; a < 16; a++) begin
      step(1, 1, 1, 3'b010, 2'b11, a[3:0], 0, "R3");
      step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R3");
      step(1, 1, 1, 3'b010, 2'b11, a[3:0], 0, "R3");
      step(1, 1, 1, 3'b010, 2'b11, a[3:0], 0, "R3");
      step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R3");
      step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R3");
    end

    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 16; a++) begin
        step(1, 1, 1, 3'b010, b[1:0], a[3:0], 0, "R4");
        step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R4");
      end

    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 16; s++)
        for (int w = 1; w >= 0; w--) begin
          step(1, 1, w[0], 3'b010, 2'b11, s[3:0], il[0], "R8");
          for (int n = 0; n < 5; n++) step(1, 0, 1'b0, 3'b000, 2'b00, 4'h0, il[0], "R8");
        end

    for (int e = 0; e < 8; e++) begin
      step(1, 1, 1, e[2:0], 2'b11, 4'h5, 0, "R5");
      step(1, 1, 0, 3'b010, 2'b00, 4'h5, 0, "R5");
      step(1, 1, 0, e[2:0], 2'b00, 4'h6, 0, "R5");
    end
    step(1, 1, 1, 3'b010, 2'b11, 4'h8, 0, "R5");
    step(1, 1, 1, 3'b110, 2'b11, 4'h8, 0, "R5");
    step(1, 0, 0, 3'b000, 2'b00, 4'h0, 0, "R5");
    step(1, 0, 0, 3'b000, 2'b00, 4'h0, 0, "R5");
    for (int a = 8; a < 12; a++) step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R5");

    step(1, 1, 1, 3'b010, 2'b11, 4'h3, 0, "R7");
    step(0, 1, 1, 3'b010, 2'b11, 4'h3, 0, "R7");
    step(1, 1, 0, 3'b010, 2'b00, 4'h3, 0, "R7");
    step(0, 1, 0, 3'b010, 2'b00, 4'h2, 0, "R7");
    step(0, 1, 1, 3'b010, 2'b01, 4'h2, 0, "R7");
    step(1, 1, 0, 3'b010, 2'b00, 4'h2, 0, "R7");
    step(0, 0, 1, 3'b010, 2'b11, 4'h2, 0, "R7");
    step(0, 0, 0, 3'b010, 2'b11, 4'h2, 0, "R7");
    idle(1);
    step(1, 1, 0, 3'b010, 2'b00, 4'h3, 0, "R7");
    idle(3);

    do_reset();
    for (int i = 0; i < 4; i++) step(1, 0, 1, 3'b010, 2'b11, i[3:0], 0, "R9");
    for (int a = 0; a < 16; a++) step(1, 1, 0, 3'b010, 2'b00, a[3:0], 0, "R9/R10");

    for (int i = 0; i < 3000; i++) begin
      logic c, l, w, il;
      logic [2:0] en;
      rnd();
      c  = lf[3:0] > 4'd1;
      l  = lf[6:4] > 3'd2;
      w  = lf[7];
      en = (lf[10:8] < 3'd6) ? 3'b010 : lf[13:11];
      il = lf[14] & lf[15];
      step(c, l, w, en, lf[17:16], lf[21:18], il, "R3");
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule